// File: doc/BRIEF.md
# Control-Word Register Datapath

This block is a small processor datapath: seven general registers, two source multiplexers and an arithmetic/logic unit. It carries out one micro-operation per clock. A 13-bit control word chooses the source of each ALU operand, the operation, and the register that captures the result. Both operand multiplexers can take an external data word in place of a register, so values can be loaded into the registers and combined with stored values.

The result of the selected operation is always visible on the output bus, together with a carry flag and a zero flag. The output bus and the flags are combinational from the control word, the external input and the register contents. A result is written into a register only at a clock edge where the control word is accepted. The control word enters on a valid/ready handshake. Ready is held high at all times, so the block never applies back-pressure. A word is accepted, and its register write takes effect, on every rising edge where valid is high. While valid is low, the output bus still shows the result of the word on the pins, but no register changes. Sequencing of control words is left to the logic in front of the block.

Top module: `cw_datapath`

## Requirements
- R1: After reset every register R1..R7 reads as zero.
- R2: Control word bits [12:10] pick the A operand and bits [9:7] pick the B operand. Codes 001..111 select registers R1..R7, and code 000 selects `ext_in`.
- R3: Bits [6:4] name the destination. On an accepted word with a code of 001..111, that register, and no other, loads the output bus value at the rising edge. Code 000 writes no register.
- R4: Opcode bits [3:0] set the arithmetic operations, all of them modulo 2^W: 0001 gives A+1, 0010 gives A+B, 0011 gives A-B and 0100 gives A-1.
- R5: Opcode 0000 passes A through. Opcode 0101 gives A AND B, 0110 gives A OR B, 0111 gives A XOR B and 1000 gives NOT A.
- R6: Opcode 1001 shifts A right by one bit and opcode 1010 shifts A left by one bit. Both shifts are logical and fill the vacated bit with zero.
- R7: Opcodes 1011..1111 drive the output bus to zero and clear carry, with no error indication. A destination code other than 000 still stores that zero.
- R8: `carry_o` is the carry out of A+B and A+1, and the borrow of A-B and A-1 (1 when the true result is negative). For a right shift it is the bit shifted out at bit 0, and for a left shift the bit shifted out at bit W-1. For every other opcode it is 0.
- R9: `zero_o` is 1 exactly when the output bus is all zeros.
- R10: `op_ready` is always 1. While `op_valid` is 0, no register changes, whatever the destination code.
- R11: When a register is both a source and the destination of one word, the operation uses its value from before the edge. The new value is visible from the next cycle on.
- R12: The word 001 011 010 0010 sets R2 to R1+R3 in a single cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Control word on `ctrl_word` is offered |
| op_ready | output | 1 | Always 1; the block accepts a word every cycle |
| ctrl_word | input | 13 | A-select, B-select, destination, opcode (MSB to LSB) |
| ext_in | input | W (8) | External operand, selected by source code 000 |
| out_bus | output | W (8) | ALU result for the current control word |
| carry_o | output | 1 | Carry or borrow or shifted-out bit of the current operation |
| zero_o | output | 1 | Output bus is zero |

## Verification
Two things can happen in the same cycle: a register is read as an operand, and the same register is written as the destination. The bench provokes this on purpose with words such as R1 = R1 + 1 and with random words whose source and destination codes collide. It then judges the output bus against the register's pre-edge value, and reads the register back in the following cycle to see the post-edge value. A reserved opcode and a null destination are also placed on the same word as a write request, to show which of the two rules wins.

// File: rtl/cw_dp_pkg.sv
package cw_dp_pkg;
  localparam int SEL_W = 3;
  localparam int OPC_W = 4;
  localparam int CW_W  = 3 * SEL_W + OPC_W;

  typedef enum logic [OPC_W-1:0] {
    OP_PASS = 4'b0000,
    OP_INC  = 4'b0001,
    OP_ADD  = 4'b0010,
    OP_SUB  = 4'b0011,
    OP_DEC  = 4'b0100,
    OP_AND  = 4'b0101,
    OP_OR   = 4'b0110,
    OP_XOR  = 4'b0111,
    OP_NOT  = 4'b1000,
    OP_SHR  = 4'b1001,
    OP_SHL  = 4'b1010
  } alu_op_e;

  typedef struct packed {
    logic [SEL_W-1:0] src_a;
    logic [SEL_W-1:0] src_b;
    logic [SEL_W-1:0] dest;
    logic [OPC_W-1:0] opc;
  } ctrl_word_t;
endpackage

// File: rtl/cw_dp_regfile.sv
module cw_dp_regfile #(
  parameter int W     = 8,
  parameter int SEL_W = 3,
  localparam int NREG = (1 << SEL_W) - 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [SEL_W-1:0]      wsel,
  input  logic [W-1:0]          wdata,
  output logic [NREG:1][W-1:0]  regs
);
  logic wr_any;
  assign wr_any = we && (wsel != '0);

  for (genvar k = 1; k <= NREG; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs[k] <= '0;
      else if (we && wsel == SEL_W'(k))
        regs[k] <= wdata;
    end

    // R3: the named destination takes the result at the edge
    assert_dest_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && wsel == SEL_W'(k)) |=> (regs[k] == $past(wdata)));
  end

  // R10 / R3: no accepted write, or a null destination, leaves every register unchanged
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_any |=> $stable(regs));
endmodule

// File: rtl/cw_dp_src_mux.sv
module cw_dp_src_mux #(
  parameter int W     = 8,
  parameter int SEL_W = 3,
  localparam int NREG = (1 << SEL_W) - 1
) (
  input  logic [NREG:1][W-1:0] regs,
  input  logic [SEL_W-1:0]     sel,
  input  logic [W-1:0]         ext,
  output logic [W-1:0]         bus
);
  always_comb begin
    bus = ext;
    for (int k = 1; k <= NREG; k++)
      if (sel == SEL_W'(k)) bus = regs[k];
  end
endmodule

// File: rtl/cw_dp_alu.sv
module cw_dp_alu
  import cw_dp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [OPC_W-1:0] opc,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  output logic [W-1:0]     res,
  output logic             carry,
  output logic             zero
);
  logic [W:0] wide;

  always_comb begin
    wide = '0;
    res  = '0;
    carry = 1'b0;
    case (opc)
      OP_PASS: res = a;
      OP_INC: begin
        wide = {1'b0, a} + {{W{1'b0}}, 1'b1};
        res = wide[W-1:0];
        carry = wide[W];
      end
      OP_ADD: begin
        wide = {1'b0, a} + {1'b0, b};
        res = wide[W-1:0];
        carry = wide[W];
      end
      OP_SUB: begin
        wide = {1'b0, a} - {1'b0, b};
        res = wide[W-1:0];
        carry = wide[W];
      end
      OP_DEC: begin
        wide = {1'b0, a} - {{W{1'b0}}, 1'b1};
        res = wide[W-1:0];
        carry = wide[W];
      end
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_NOT: res = ~a;
      OP_SHR: begin
        res = {1'b0, a[W-1:1]};
        carry = a[0];
      end
      OP_SHL: begin
        res = {a[W-2:0], 1'b0};
        carry = a[W-1];
      end
      default: begin
        res = '0;
        carry = 1'b0;
      end
    endcase
    zero = (res == '0);
  end
endmodule

// File: rtl/cw_datapath.sv
module cw_datapath
  import cw_dp_pkg::*;
#(
  parameter int W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  output logic            op_ready,
  input  logic [CW_W-1:0] ctrl_word,
  input  logic [W-1:0]    ext_in,
  output logic [W-1:0]    out_bus,
  output logic            carry_o,
  output logic            zero_o
);
  localparam int NREG = (1 << SEL_W) - 1;

  ctrl_word_t cw;
  logic [NREG:1][W-1:0] regs;
  logic [W-1:0] a_bus, b_bus;

  assign cw = ctrl_word_t'(ctrl_word);
  assign op_ready = 1'b1;

  cw_dp_src_mux #(.W(W), .SEL_W(SEL_W)) u_mux_a (
    .regs(regs), .sel(cw.src_a), .ext(ext_in), .bus(a_bus));
  cw_dp_src_mux #(.W(W), .SEL_W(SEL_W)) u_mux_b (
    .regs(regs), .sel(cw.src_b), .ext(ext_in), .bus(b_bus));

  cw_dp_alu #(.W(W)) u_alu (
    .opc(cw.opc), .a(a_bus), .b(b_bus),
    .res(out_bus), .carry(carry_o), .zero(zero_o));

  cw_dp_regfile #(.W(W), .SEL_W(SEL_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(op_valid && op_ready),
    .wsel(cw.dest), .wdata(out_bus), .regs(regs));

  // R2: source code 000 with a pass-through shows the external word at the output
  assert_ext_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cw.src_a == '0 && cw.opc == OP_PASS) |-> (out_bus == ext_in));

  // R7: reserved opcodes give a zero result with carry clear
  assert_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cw.opc > OP_SHL) |-> (out_bus == '0 && zero_o && !carry_o));

  // R6: shifts fill the vacated bit with zero
  assert_shl_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cw.opc == OP_SHL) |-> (out_bus[0] == 1'b0));
  assert_shr_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cw.opc == OP_SHR) |-> (out_bus[W-1] == 1'b0));
endmodule

// File: tb/cw_datapath_tb.sv
module cw_datapath_tb;
  localparam int W = 8;
  localparam int HALF = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_valid = 1'b0;
  logic op_ready;
  logic [12:0] ctrl_word = '0;
  logic [W-1:0] ext_in = '0;
  logic [W-1:0] out_bus;
  logic carry_o, zero_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [W-1:0] m [0:7];

  always #HALF clk = ~clk;

  cw_datapath #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
    .ctrl_word(ctrl_word), .ext_in(ext_in), .out_bus(out_bus),
    .carry_o(carry_o), .zero_o(zero_o));

  function automatic logic [W:0] model_alu(input logic [3:0] op,
                                           input logic [W-1:0] a,
                                           input logic [W-1:0] b);
    logic [W:0] r;
    case (op)
      4'd0:  r = {1'b0, a};
      4'd1:  r = {1'b0, a} + 1;
      4'd2:  r = {1'b0, a} + {1'b0, b};
      4'd3:  r = {(a < b), a - b};
      4'd4:  r = {(a == 0), a - 8'd1};
      4'd5:  r = {1'b0, a & b};
      4'd6:  r = {1'b0, a | b};
      4'd7:  r = {1'b0, a ^ b};
      4'd8:  r = {1'b0, ~a};
      4'd9:  r = {a[0], 1'b0, a[W-1:1]};
      4'd10: r = {a[W-1], a[W-2:0], 1'b0};
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string op_req(input logic [3:0] op);
    if (op == 4'd0 || (op >= 4'd5 && op <= 4'd8)) return "R5";
    if (op >= 4'd1 && op <= 4'd4) return "R4";
    if (op == 4'd9 || op == 4'd10) return "R6";
    return "R7";
  endfunction

  function automatic logic [12:0] mk(input int sa, input int sb, input int sd, input int op);
    return {sa[2:0], sb[2:0], sd[2:0], op[3:0]};
  endfunction

  task automatic check(input string req, input string what, input logic [W:0] act, input logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive after a falling edge, check, then pass the rising edge
  task automatic step(input logic [12:0] cw, input logic v, input logic [W-1:0] ext, input string req);
    logic [W-1:0] a, b;
    logic [W:0] e;
    ctrl_word = cw;
    op_valid = v;
    ext_in = ext;
    #2;
    a = (cw[12:10] == 0) ? ext : m[cw[12:10]];
    b = (cw[9:7] == 0) ? ext : m[cw[9:7]];
    e = model_alu(cw[3:0], a, b);
    check(req, "out_bus", {1'b0, out_bus}, {1'b0, e[W-1:0]});
    check("R8", "carry", {{W{1'b0}}, carry_o}, {{W{1'b0}}, e[W]});
    check("R9", "zero", {{W{1'b0}}, zero_o}, {{W{1'b0}}, (e[W-1:0] == 0)});
    check("R10", "ready", {{W{1'b0}}, op_ready}, {{W{1'b0}}, 1'b1});
    @(posedge clk);
    if (v && cw[6:4] != 0) m[cw[6:4]] = e[W-1:0];
    @(negedge clk);
  endtask

  task automatic read_reg(input int k, input string req);
    ctrl_word = mk(k, 0, 0, 0);
    op_valid = 1'b0;
    #2;
    check(req, $sformatf("R%0d readback", k), {1'b0, out_bus}, {1'b0, m[k]});
    @(negedge clk);
  endtask

  initial begin
    #(2 * HALF * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int k = 0; k < 8; k++) m[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int k = 1; k <= 7; k++) read_reg(k, "R1");

    // R2: load from external input, R12: worked example R2 = R1 + R3
    step(mk(0, 0, 1, 0), 1'b1, 8'h05, "R2");
    step(mk(0, 0, 3, 0), 1'b1, 8'h09, "R2");
    step(13'b001_011_010_0010, 1'b1, 8'hEE, "R12");
    read_reg(2, "R12");
    check("R12", "R2 value", {1'b0, m[2]}, 9'h00E);

    // R11: read-before-write on the same register
    step(mk(1, 0, 1, 1), 1'b1, 8'h00, "R11");
    read_reg(1, "R11");
    check("R11", "R1 after inc", {1'b0, m[1]}, 9'h006);

    // R7: reserved opcode with a destination stores zero
    step(mk(0, 0, 4, 0), 1'b1, 8'hA5, "R2");
    step(mk(4, 4, 4, 13), 1'b1, 8'h77, "R7");
    read_reg(4, "R7");

    // R3: null destination writes nothing
    step(mk(0, 0, 0, 0), 1'b1, 8'h3C, "R3");
    for (int k = 1; k <= 7; k++) read_reg(k, "R3");

    // R10: valid low blocks the write
    step(mk(0, 0, 5, 0), 1'b0, 8'h99, "R10");
    read_reg(5, "R10");

    // R8 corners: carry out of add, borrow of dec and sub, shifted-out bits
    step(mk(0, 0, 6, 0), 1'b1, 8'hFF, "R2");
    step(mk(6, 6, 7, 2), 1'b1, 8'h00, "R4");
    step(mk(0, 0, 0, 4), 1'b1, 8'h00, "R4");
    step(mk(1, 6, 0, 3), 1'b1, 8'h00, "R4");
    step(mk(6, 0, 0, 9), 1'b1, 8'h00, "R6");
    step(mk(6, 0, 0, 10), 1'b1, 8'h00, "R6");
    step(mk(0, 0, 0, 1), 1'b1, 8'hFF, "R4");

    // random words, including reserved codes and source/destination collisions
    for (int i = 0; i < 600; i++) begin
      logic [12:0] cw;
      logic v;
      cw = 13'($urandom);
      v = ($urandom % 4) != 0;
      step(cw, v, 8'($urandom), op_req(cw[3:0]));
    end
    for (int k = 1; k <= 7; k++) read_reg(k, "R3");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule